// File: doc/BRIEF.md
# Reloadable 16-bit Down Timer

This block is a 16-bit down counter with a 16-bit reload register. A processor reaches it over an 8-bit bus, one byte at a time. Each count pulse lowers the counter by one. A pulse that arrives while the counter is zero is an underflow: the counter is refilled from the reload register and keeps running with no software help. An underflow also sets an interrupt request flag. When enabled, it flips a toggle output and loads two preset bits onto a small output port.

The count pulses come from one of two sources. The first is a free-running prescaler that divides the clock by 16. The second is the synchronised edges of an external input, rising or falling as chosen. Software can halt counting with a stop bit. It can also decide whether a 16-bit write goes to both the counter and the reload register or to the reload register only. The bus access order keeps 16-bit values coherent. A high-byte read freezes the low byte for the read that follows. A low-byte write waits in a holding register until the high byte arrives.

Top module: `reload_timer16`

## Requirements
- R1: After reset the counter, reload value, holding and shadow bytes are 0. The control byte reads 0x01 (stopped). irq_flag, pulse_out and rt_port are 0. The reset release passes through a two-stage synchroniser.
- R2: Each count pulse lowers a non-zero counter by 1. A count pulse while the counter is 0 is an underflow, and it copies the reload value into the counter.
- R3: An underflow sets irq_flag to 1. irq_clr clears it one cycle later, unless an underflow happens in the same cycle, in which case the set wins.
- R4: A read at address 1 returns the counter high byte and captures the counter low byte into a shadow register. A read at address 0 returns the shadow byte.
- R5: A write at address 0 only fills a holding byte. A write at address 1 forms {wdata, holding byte}. With control bit 1 at 0, that value goes to both the reload register and the counter. With control bit 1 at 1, it goes to the reload register only.
- R6: With control bit 2 at 0, a count pulse occurs once every 16 clocks, from a free-running prescaler.
- R7: With control bit 2 at 1, edges of ext_cnt_in are counted after a two-flop synchroniser. Control bit 3 at 0 selects rising edges and at 1 selects falling edges. An edge changes the counter on the third clock edge after the pin changes.
- R8: A write to control (address 2) sets the toggle flip-flop to the new value of bit 3. Each underflow inverts it. pulse_out is the toggle value while control bit 4 is 1, and 0 otherwise.
- R9: When control bit 5 is 1, each underflow loads control bits 7:6 into rt_port (bit 6 to rt_port[0]). At all other times rt_port holds its value.
- R10: While control bit 0 (stop) is 1, count pulses are ignored and the counter holds its value.
- R11: If a high-byte write and a count pulse fall in the same cycle, the write wins and that pulse is dropped.
- R12: Address 2 reads back the control byte. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (a read at address 1 captures the shadow byte) |
| addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq_clr | input | 1 | Clears the interrupt request flag |
| ext_cnt_in | input | 1 | External count input |
| irq_flag | output | 1 | Interrupt request flag |
| pulse_out | output | 1 | Toggle output |
| rt_port | output | 2 | Port bits loaded on underflow |

## Verification
The hardest case to reach is a count pulse landing in the same clock as a high-byte write, since the prescaler phase is hidden. The bench reaches it with the external source instead. It changes the pin and then issues the high-byte write exactly two falling edges later, so the write meets the pulse that the synchroniser releases. Reload-only writes are checked through the length of the next underflow period, because the reload register has no direct read path.

// File: rtl/rt16_pkg.sv
package rt16_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [1:0] rt_data;
    logic       rt_en;
    logic       pulse_mode;
    logic       fall_edge;
    logic       ext_src;
    logic       latch_only;
    logic       stop;
  } ctrl_t;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam ctrl_t CTRL_RESET = '{rt_data: 2'b00, rt_en: 1'b0, pulse_mode: 1'b0,
                                   fall_edge: 1'b0, ext_src: 1'b0, latch_only: 1'b0,
                                   stop: 1'b1};
endpackage

// File: rtl/rt16_prescaler.sv
module rt16_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] cnt_q, cnt_d;
      logic          wrap;

      always_comb begin
        wrap  = (cnt_q == PW'(DIV - 1));
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = wrap;

      // R6: pulses are at least two clocks apart
      assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rt16_edge_sync.sv
module rt16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R7: a detected edge never reads as both polarities
  assert_edge_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
endmodule

// File: rtl/rt16_core.sv
module rt16_core #(
  parameter int DATA_W = 8,
  parameter int RT_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pulse_i,
  input  logic                  stop_i,
  input  logic                  latch_only_i,
  input  logic                  rt_en_i,
  input  logic [RT_W-1:0]       rt_data_i,
  input  logic                  load_i,
  input  logic [2*DATA_W-1:0]   load_val_i,
  input  logic                  ctrl_wr_i,
  input  logic                  tff_init_i,
  input  logic                  irq_clr_i,
  output logic [2*DATA_W-1:0]   count_o,
  output logic                  irq_o,
  output logic                  tff_o,
  output logic [RT_W-1:0]       rt_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             irq_q, irq_d;
  logic             tff_q, tff_d;
  logic [RT_W-1:0]  rt_q, rt_d;
  logic             count_go, underflow;

  always_comb begin
    count_go  = pulse_i && !stop_i && !load_i;
    underflow = count_go && (count_q == '0);

    count_d = count_q;
    if (load_i && !latch_only_i) count_d = load_val_i;
    else if (underflow)          count_d = reload_q;
    else if (count_go)           count_d = count_q - 1'b1;

    reload_d = load_i ? load_val_i : reload_q;

    irq_d = irq_q;
    if (underflow)      irq_d = 1'b1;
    else if (irq_clr_i) irq_d = 1'b0;

    tff_d = tff_q;
    if (ctrl_wr_i)      tff_d = tff_init_i;
    else if (underflow) tff_d = ~tff_q;

    rt_d = (underflow && rt_en_i) ? rt_data_i : rt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      irq_q    <= 1'b0;
      tff_q    <= 1'b0;
      rt_q     <= '0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
      irq_q    <= irq_d;
      tff_q    <= tff_d;
      rt_q     <= rt_d;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
  assign tff_o   = tff_q;
  assign rt_o    = rt_q;

  // R2: an ordinary pulse decrements by one
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !stop_i && !load_i && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
  // R2: an underflow refills from the reload register
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !stop_i && !load_i && count_q == '0) |=> count_q == $past(reload_q));
  // R3: an underflow leaves the flag set
  assert_irq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !stop_i && !load_i && count_q == '0) |=> irq_q);
  // R8: an underflow without a control write inverts the toggle
  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !stop_i && !load_i && count_q == '0 && !ctrl_wr_i) |=> tff_q != $past(tff_q));
  // R9: an enabled underflow loads the preset bits
  assert_rt_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !stop_i && !load_i && count_q == '0 && rt_en_i) |=> rt_q == $past(rt_data_i));
  // R10: the counter holds while stopped
  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> count_q == $past(count_q));
  // R5, R11: a full write lands in the counter whatever pulse comes with it
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !latch_only_i) |=> count_q == $past(load_val_i));
  // R5: a reload-only write leaves the counter untouched by itself
  assert_latch_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && latch_only_i) |=> count_q == $past(count_q));
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int PRESCALE    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       irq_clr,
  input  logic       ext_cnt_in,
  output logic       irq_flag,
  output logic       pulse_out,
  output logic [1:0] rt_port
);
  import rt16_pkg::*;
  localparam int CNT_W = 2 * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // bus decode
  reg_sel_e sel;
  logic     wr_lo, wr_hi, wr_ctrl, rd_hi;
  always_comb begin
    sel     = reg_sel_e'(addr);
    wr_lo   = wr_en && (sel == REG_LO);
    wr_hi   = wr_en && (sel == REG_HI);
    wr_ctrl = wr_en && (sel == REG_CTRL);
    rd_hi   = rd_en && (sel == REG_HI);
  end

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0]  count;

  always_comb begin
    ctrl_d   = wr_ctrl ? ctrl_t'(wdata) : ctrl_q;
    hold_d   = wr_lo ? wdata : hold_q;
    shadow_d = rd_hi ? count[DATA_W-1:0] : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q   <= CTRL_RESET;
      hold_q   <= '0;
      shadow_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      hold_q   <= hold_d;
      shadow_q <= shadow_d;
    end
  end

  // count pulse sources
  logic presc_tick, ext_rise, ext_fall, ext_pulse, count_pulse;

  rt16_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (presc_tick)
  );

  rt16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (ext_cnt_in),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  always_comb begin
    ext_pulse   = ctrl_q.fall_edge ? ext_fall : ext_rise;
    count_pulse = ctrl_q.ext_src ? ext_pulse : presc_tick;
  end

  logic tff;

  rt16_core #(.DATA_W(DATA_W), .RT_W(2)) u_core (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .pulse_i      (count_pulse),
    .stop_i       (ctrl_q.stop),
    .latch_only_i (ctrl_q.latch_only),
    .rt_en_i      (ctrl_q.rt_en),
    .rt_data_i    (ctrl_q.rt_data),
    .load_i       (wr_hi),
    .load_val_i   ({wdata, hold_q}),
    .ctrl_wr_i    (wr_ctrl),
    .tff_init_i   (wdata[3]),
    .irq_clr_i    (irq_clr),
    .count_o      (count),
    .irq_o        (irq_flag),
    .tff_o        (tff),
    .rt_o         (rt_port)
  );

  assign pulse_out = ctrl_q.pulse_mode & tff;

  always_comb begin
    unique case (sel)
      REG_LO:   rdata = shadow_q;
      REG_HI:   rdata = count[CNT_W-1:DATA_W];
      REG_CTRL: rdata = ctrl_q;
      default:  rdata = '0;
    endcase
  end

  // R4: a high-byte read freezes the low byte seen at that moment
  assert_shadow_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_hi |=> shadow_q == $past(count[DATA_W-1:0]));
  // R5: the holding byte changes only on a low-byte write
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_lo |=> hold_q == $past(hold_q));
  // R8: with pulse mode off the pin stays low
  assert_pulse_off_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctrl_q.pulse_mode |-> !pulse_out);
endmodule

// File: tb/reload_timer16_test.sv
module reload_timer16_test;
  logic       clk;
  logic       rst_n;
  logic       wr_en, rd_en, irq_clr, ext_cnt_in;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_flag, pulse_out;
  logic [1:0] rt_port;

  reload_timer16 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_clr(irq_clr), .ext_cnt_in(ext_cnt_in),
    .irq_flag(irq_flag), .pulse_out(pulse_out), .rt_port(rt_port)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_rel, m_hold, m_shadow, m_ctrl, m_psc;
  bit m_irq, m_tff, m_r1, m_r2, m_s1, m_s2, m_prev;
  int m_rt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      m_cnt = 0; m_rel = 0; m_hold = 0; m_shadow = 0; m_ctrl = 1; m_psc = 0;
      m_irq = 0; m_tff = 0; m_rt = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      if (m_r2) begin
        bit pulse, load, cwr, go, uf;
        int n_cnt;
        if (m_ctrl[2]) pulse = m_ctrl[3] ? (!m_s2 && m_prev) : (m_s2 && !m_prev);
        else           pulse = (m_psc == 15);
        load = wr_en && addr == 1;
        cwr  = wr_en && addr == 2;
        go   = pulse && !m_ctrl[0] && !load;
        uf   = go && m_cnt == 0;
        n_cnt = m_cnt;
        if (load && !m_ctrl[1]) n_cnt = wdata * 256 + m_hold;
        else if (uf)            n_cnt = m_rel;
        else if (go)            n_cnt = m_cnt - 1;
        if (rd_en && addr == 1) m_shadow = m_cnt % 256;
        if (load) m_rel = wdata * 256 + m_hold;
        m_cnt = n_cnt;
        if (uf) m_irq = 1; else if (irq_clr) m_irq = 0;
        if (cwr) m_tff = wdata[3]; else if (uf) m_tff = !m_tff;
        if (uf && m_ctrl[5]) m_rt = (m_ctrl >> 6) & 3;
        if (cwr) m_ctrl = wdata;
        if (wr_en && addr == 0) m_hold = wdata;
        m_psc  = (m_psc == 15) ? 0 : m_psc + 1;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_cnt_in;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  // per-clock comparison of every output against the model
  always begin
    @(posedge clk);
    #3;
    if (rst_n && m_r2 && !done) begin
      int exp_rd;
      case (addr)
        2'd0: exp_rd = m_shadow;
        2'd1: exp_rd = m_cnt / 256;
        2'd2: exp_rd = m_ctrl;
        default: exp_rd = 0;
      endcase
      chk("R4/R12 rdata vs model", rdata, exp_rd);
      chk("R3 irq_flag vs model", irq_flag, m_irq);
      chk("R8 pulse_out vs model", pulse_out, m_ctrl[4] & m_tff);
      chk("R9 rt_port vs model", rt_port, m_rt);
    end
  end

  // ---------------- bus tasks (called just after a falling edge) ----------------
  task automatic bw(input int a, input int d);
    addr = 2'(a); wdata = 8'(d); wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic br(input int a, output int v);
    addr = 2'(a); rd_en = 1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd16(output int v);
    int hi, lo;
    br(1, hi);
    br(0, lo);
    v = hi * 256 + lo;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(output int t);
    int k;
    k = 0;
    while (!irq_flag && k < 2000) begin @(negedge clk); k++; end
    t = cyc;
  endtask

  task automatic clr_irq();
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic pin(input bit v);
    ext_cnt_in = v;
    idle(4);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
      $finish;
    end
  end

  // ---------------- directed scenarios ----------------
  initial begin
    int v, v1, t0, t1, t2;
    rst_n = 0; wr_en = 0; rd_en = 0; irq_clr = 0; ext_cnt_in = 0;
    addr = 0; wdata = 0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R1: reset state
    rd16(v);  chk("R1 counter after reset", v, 0);
    br(2, v); chk("R1 control after reset", v, 8'h01);
    chk("R1 irq after reset", irq_flag, 0);
    chk("R1 pulse_out after reset", pulse_out, 0);
    chk("R1 rt_port after reset", rt_port, 0);
    br(3, v); chk("R12 unused address", v, 0);

    // R5: low byte alone is held, high byte commits
    bw(0, 8'h34);
    rd16(v); chk("R5 low write alone leaves counter", v, 0);
    bw(1, 8'h12);
    rd16(v); chk("R5 full write to counter", v, 16'h1234);

    // R10: stopped counter holds
    idle(100);
    rd16(v); chk("R10 stopped counter holds", v, 16'h1234);

    // R6, R8, R9: internal source, period and underflow side effects
    bw(0, 8'h03); bw(1, 8'h00);
    bw(2, 8'hB0);               // run, pulse mode, rt enable, preset 2'b10, edge bit 0
    chk("R8 toggle starts at edge bit", pulse_out, 0);
    chk("R9 rt_port holds before underflow", rt_port, 0);
    wait_irq(t0);
    chk("R3 irq set on underflow", irq_flag, 1);
    chk("R8 toggle after first underflow", pulse_out, 1);
    chk("R9 rt_port loaded on underflow", rt_port, 2);
    clr_irq();
    chk("R3 irq cleared", irq_flag, 0);
    wait_irq(t1);
    chk("R6 underflow period with reload 3", t1 - t0, 64);
    chk("R8 toggle after second underflow", pulse_out, 0);
    clr_irq();

    // R5: reload-only write shows up only in the next period
    bw(2, 8'h03);
    rd16(v1);
    bw(0, 8'h05); bw(1, 8'h00);
    rd16(v); chk("R5 reload-only write keeps counter", v, v1);
    bw(2, 8'h02);
    wait_irq(t1);
    clr_irq();
    wait_irq(t2);
    chk("R5 period follows new reload value", t2 - t1, 96);
    clr_irq();

    // R7: external rising edges
    bw(2, 8'h05);
    bw(0, 8'h02); bw(1, 8'h00);
    bw(2, 8'h04);
    pin(1); pin(0); pin(1); pin(0);
    bw(2, 8'h05);
    rd16(v); chk("R7 two rising edges counted", v, 0);
    chk("R7 no underflow yet", irq_flag, 0);
    bw(2, 8'h0C);               // falling edges, running
    pin(1);
    rd16(v); chk("R7 rising edge ignored in falling mode", v, 0);
    pin(0);
    rd16(v); chk("R2 underflow reloads from latch", v, 2);
    chk("R3 irq after external underflow", irq_flag, 1);
    clr_irq();

    // R11: high-byte write meets a count pulse
    bw(2, 8'h04);               // rising edges, running; pin is low
    bw(0, 8'h10);
    ext_cnt_in = 1;
    @(negedge clk);
    @(negedge clk);
    bw(1, 8'h00);
    bw(2, 8'h05);
    rd16(v); chk("R11 write wins over coincident pulse", v, 16'h0010);

    // R10: edges while stopped change nothing
    pin(0); pin(1); pin(0);
    rd16(v); chk("R10 edges ignored while stopped", v, 16'h0010);

    idle(5);
    done = 1;
    summary();
    $finish;
  end
endmodule